// File: doc/BRIEF.md
# BB84 Qubit Link Emulator

This block models, in plain digital logic, the photon path of a BB84 key exchange. Each cycle the sender offers one data bit and one basis bit. The block turns this pair into one of four two-bit polarization-state codes. An eavesdropper stage may then corrupt the code. The receiver reads the result with its own basis bit. When the receiver's basis agrees with the basis carried by the code, the block returns a definite recovered bit. When the two bases disagree, it raises an explicit indeterminate flag instead of producing an unknown value.

The block is a three-stage pipeline with one item per cycle. The stages are encode, tamper and decode. `in_valid` travels alongside the data, so a result appears on the third clock edge after its inputs are sampled. The receiver basis and the spy control are sampled in the same cycle as the sender's bits. Each item therefore carries its own receiver basis and spy setting through the pipeline. Random bit sources, sifting over the classical channel and error-rate estimation belong to the surrounding design.

Top module: `bb84_link`

## Requirements
- R1: Without the spy, if `rx_basis` equals `tx_basis`, the output item has `rx_indet` = 0 and `rx_bit` = `tx_data`.
- R2: Without the spy, if `rx_basis` differs from `tx_basis`, the output item has `rx_indet` = 1 and `rx_bit` = 0.
- R3: The state code puts the basis in bit 1 and the data in bit 0 (rectangular 0 = 00, rectangular 1 = 01, diagonal 0 = 10, diagonal 1 = 11). With `spy_en` = 1, both bits of the code are inverted. As a result, if `rx_basis` equals `tx_basis`, the output has `rx_indet` = 1 and `rx_bit` = 0.
- R4: With `spy_en` = 1 and `rx_basis` different from `tx_basis`, the output has `rx_indet` = 0 and `rx_bit` = NOT `tx_data`.
- R5: `out_valid` is high after clock edge n+2 exactly when `in_valid` was high at clock edge n. This gives a latency of three cycles, counting the input cycle.
- R6: While `out_valid` is low, `rx_bit` and `rx_indet` are both 0.
- R7: A synchronous active-high `rst` clears all three stages. Items already in flight never appear at the output.
- R8: `rx_basis` and `spy_en` are taken at the same edge as `tx_data` and `tx_basis`. Later changes to these inputs do not affect an item already in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sender bits valid this cycle |
| tx_data | input | 1 | Sender data bit |
| tx_basis | input | 1 | Sender basis (0 rectangular, 1 diagonal) |
| rx_basis | input | 1 | Receiver basis (0 rectangular, 1 diagonal) |
| spy_en | input | 1 | Eavesdropper present for this item |
| out_valid | output | 1 | Recovered result valid |
| rx_bit | output | 1 | Recovered data bit |
| rx_indet | output | 1 | Result indeterminate (basis mismatch) |

## Verification
A wrong state code or a missing inversion shows up at the ports as a swapped definite/indeterminate outcome, or as an inverted recovered bit. It appears on the third edge after the affected input and only for some combinations of the four input bits. All sixteen combinations are therefore driven explicitly before the random traffic starts. A stage that loses or duplicates valid bits shifts `out_valid` against the input pattern at once. A stage that samples `rx_basis` or `spy_en` late shows up only when those inputs change while an item is in flight, which the random stimulus does on most cycles.

// File: rtl/bb84_link.sv
module bb84_link (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic tx_data,
  input  logic tx_basis,
  input  logic rx_basis,
  input  logic spy_en,
  output logic out_valid,
  output logic rx_bit,
  output logic rx_indet
);

  localparam logic [1:0] ST_RECT0 = 2'b00;
  localparam logic [1:0] ST_RECT1 = 2'b01;
  localparam logic [1:0] ST_DIAG0 = 2'b10;
  localparam logic [1:0] ST_DIAG1 = 2'b11;

  logic [1:0] enc_q, chan_q;
  logic       enc_v, chan_v;
  logic       enc_rxb, chan_rxb, enc_spy;
  logic [1:0] enc_d;
  logic       match;

  always_comb begin
    case ({tx_basis, tx_data})
      2'b00:   enc_d = ST_RECT0;
      2'b01:   enc_d = ST_RECT1;
      2'b10:   enc_d = ST_DIAG0;
      default: enc_d = ST_DIAG1;
    endcase
  end

  assign match = (chan_q[1] == chan_rxb);

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_v     <= 1'b0;
      chan_v    <= 1'b0;
      out_valid <= 1'b0;
      enc_q     <= ST_RECT0;
      chan_q    <= ST_RECT0;
      enc_rxb   <= 1'b0;
      chan_rxb  <= 1'b0;
      enc_spy   <= 1'b0;
      rx_bit    <= 1'b0;
      rx_indet  <= 1'b0;
    end else begin
      enc_v     <= in_valid;
      enc_q     <= enc_d;
      enc_rxb   <= rx_basis;
      enc_spy   <= spy_en;
      chan_v    <= enc_v;
      chan_q    <= enc_spy ? ~enc_q : enc_q;
      chan_rxb  <= enc_rxb;
      out_valid <= chan_v;
      rx_bit    <= chan_v & match & chan_q[0];
      rx_indet  <= chan_v & ~match;
    end
  end

endmodule

module bb84_link_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic tx_data,
  input logic tx_basis,
  input logic rx_basis,
  input logic spy_en,
  input logic out_valid,
  input logic rx_bit,
  input logic rx_indet
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !out_valid && !rx_bit && !rx_indet); // R7
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst) (age == 2'd3) |-> out_valid == $past(in_valid, 3)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) !out_valid |-> !rx_bit && !rx_indet); // R6
  AST_CLEAN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid, 3) && !$past(spy_en, 3) && $past(tx_basis, 3) == $past(rx_basis, 3))
    |-> !rx_indet && rx_bit == $past(tx_data, 3)); // R1
  AST_CLEAN_MISS: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid, 3) && !$past(spy_en, 3) && $past(tx_basis, 3) != $past(rx_basis, 3))
    |-> rx_indet && !rx_bit); // R2
  AST_SPY_SAME: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid, 3) && $past(spy_en, 3) && $past(tx_basis, 3) == $past(rx_basis, 3))
    |-> rx_indet && !rx_bit); // R3
  AST_SPY_CROSS: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && $past(in_valid, 3) && $past(spy_en, 3) && $past(tx_basis, 3) != $past(rx_basis, 3))
    |-> !rx_indet && rx_bit == !$past(tx_data, 3)); // R4
endmodule

bind bb84_link bb84_link_chk u_chk (.*);

// File: tb/bb84_link_bench.sv
module bb84_link_bench;
  logic clk = 1'b0;
  logic rst, in_valid, tx_data, tx_basis, rx_basis, spy_en;
  logic out_valid, rx_bit, rx_indet;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic hv[3], hd[3], hb[3], hr[3], hs[3];
  string tag_force = "";

  always #5 clk = ~clk;

  bb84_link u_bb84_link (.*);

  function automatic logic exp_indet(logic b, logic r, logic s);
    return s ? (b == r) : (b != r);
  endfunction

  function automatic logic exp_bit(logic d, logic b, logic r, logic s);
    if (exp_indet(b, r, s)) return 1'b0;
    return s ? ~d : d;
  endfunction

  function automatic string req_of(logic b, logic r, logic s);
    if (!s) return (b == r) ? "R1" : "R2";
    return (b == r) ? "R3" : "R4";
  endfunction

  task automatic check3(string req, logic v, logic bt, logic ind);
    checks++;
    if (out_valid !== v || rx_bit !== bt || rx_indet !== ind) begin
      errors++;
      $display("FAIL %s: got v=%b bit=%b indet=%b expected v=%b bit=%b indet=%b",
               req, out_valid, rx_bit, rx_indet, v, bt, ind);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 3; i++) hv[i] = 1'b0;
    end else begin
      for (int i = 2; i > 0; i--) begin
        hv[i] = hv[i-1]; hd[i] = hd[i-1]; hb[i] = hb[i-1];
        hr[i] = hr[i-1]; hs[i] = hs[i-1];
      end
      hv[0] = in_valid; hd[0] = tx_data; hb[0] = tx_basis;
      hr[0] = rx_basis; hs[0] = spy_en;
    end
    @(negedge clk);
    if (tag_force != "") check3(tag_force, 1'b0, 1'b0, 1'b0);
    else if (!hv[2]) check3("R6/R5", 1'b0, 1'b0, 1'b0);
    else check3({req_of(hb[2], hr[2], hs[2]), "/R5/R8"}, 1'b1,
                exp_bit(hd[2], hb[2], hr[2], hs[2]), exp_indet(hb[2], hr[2], hs[2]));
  endtask

  task automatic drive(logic v, logic d, logic b, logic r, logic s);
    in_valid = v; tx_data = d; tx_basis = b; rx_basis = r; spy_en = s;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      hv[i] = 0; hd[i] = 0; hb[i] = 0; hr[i] = 0; hs[i] = 0;
    end
    rst = 1'b1;
    drive(1, 1, 1, 1, 1);
    tag_force = "R7";
    step(); step();
    rst = 1'b0;
    drive(0, 0, 0, 0, 0);
    step();
    tag_force = "";
    for (int k = 0; k < 16; k++) begin
      drive(1, k[0], k[1], k[2], k[3]);
      step();
    end
    drive(0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step();
    void'($urandom(32'd84));
    for (int k = 0; k < 3000; k++) begin
      drive($urandom % 4 != 0, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4 == 0);
      step();
    end
    drive(1, 1, 0, 0, 0);
    step(); step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    drive(0, 0, 0, 0, 0);
    tag_force = "R7";
    step(); step(); step();
    tag_force = "";
    for (int k = 0; k < 4; k++) step();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule